// File: doc/BRIEF.md
# Ring-Chained Reloading Event Down-Counter

This block holds a set of event-counting down-counters, three by default. Each one is 16 bits wide. A channel takes its events from one of two places: edges on its own external pin, or the underflow pulses of the channel before it in a ring. In the ring, channel 0 is fed by the last channel. When a channel passes zero it reloads from its reload register, keeps counting, and raises a one-cycle interrupt request. A loaded value n therefore divides the event rate by n+1.

Software drives each channel through two registers on a small register port: a timer register and a mode register. A write to the timer register reaches both the live counter and the reload register while the channel is stopped. The same holds after a start, up to the first counted event. After that event, a write reaches the reload register alone. Pin inputs are synchronised to the clock before their edges are detected.

Top module: `evt_tmr_ring`

## Requirements
- R1: After reset every live count, reload value and mode register reads as zero, and no interrupt request is asserted.
- R2: Each qualifying event lowers the live count by one. An event at count zero loads the reload value instead, so a loaded value n gives one underflow per n+1 events.
- R3: With the pin source selected, mode bits [1:0] pick the counted edges: 00 falling only, 01 rising only, 10 both.
- R4: When mode bit 2 is 1, a channel counts the underflows of channel i-1, and channel 0 counts those of the last channel. Each underflow pulse is one event in the cycle it is asserted.
- R5: When the cascade source is selected, pin edges have no effect on the count.
- R6: Mode bit 3 is the start bit. While it is 0, events are ignored and the live count holds.
- R7: A timer register write updates both the live count and the reload value in two cases: while the channel is stopped, and after start until its first counted event.
- R8: Once the first event after start has been counted, a timer register write changes only the reload value. The counter takes the new value at the next underflow.
- R9: Each underflow raises that channel's interrupt request for exactly one clock cycle.
- R10: The address is 2*channel + sel, where sel 0 is the timer register and sel 1 is the mode register. A read returns the live count or the mode bits, with rd_valid and rd_data one cycle after rd_en.
- R11: Clearing and then setting the start bit clears the first-event record, so a write after a restart updates the live count again.
- R12: A pin level change that is held for any number of cycles is counted exactly once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | NUM_CH | Asynchronous external event inputs, one per channel |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Register address, 2*channel + sel |
| wr_data | input | CNT_W | Write data |
| rd_data | output | CNT_W | Registered read data |
| rd_valid | output | 1 | Read data valid, one cycle after rd_en |
| irq | output | NUM_CH | One-cycle underflow interrupt requests |

## Verification
The assertions assume the mode field never holds the reserved edge code 11. They also assume that reads and writes never share a cycle, since both use the single address. The stimulus writes only the three legal edge codes and issues each register access in its own cycle. It changes a pin only at the falling clock edge and holds each level for at least six cycles, so every edge passes the synchroniser before the next change arrives.

// File: rtl/evt_tmr_pkg.sv
package evt_tmr_pkg;

  typedef enum logic [1:0] {
    EDGE_FALL = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_BOTH = 2'b10,
    EDGE_RSVD = 2'b11
  } edge_sel_e;

  // bit 3 start, bit 2 cascade source, bits 1:0 edge select
  typedef struct packed {
    logic      start;
    logic      casc;
    edge_sel_e pol;
  } chan_mode_t;

  localparam int MODE_W = $bits(chan_mode_t);

endpackage

// File: rtl/evt_pin_edge.sv
module evt_pin_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
      last_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign rise_o = sync_q[SYNC_STAGES-1] & ~last_q;
  assign fall_o = ~sync_q[SYNC_STAGES-1] & last_q;

endmodule

// File: rtl/evt_chan.sv
module evt_chan
  import evt_tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  chan_mode_t       mode_i,
  input  logic             pin_rise_i,
  input  logic             pin_fall_i,
  input  logic             casc_i,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wr_data_i,
  output logic [CNT_W-1:0] count_o,
  output logic             uflow_o
);

  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] reload_q;
  logic             seen_q;
  logic             uflow_q;
  logic             pin_evt;
  logic             evt;
  logic             locked;

  always_comb begin
    unique case (mode_i.pol)
      EDGE_FALL: pin_evt = pin_fall_i;
      EDGE_RISE: pin_evt = pin_rise_i;
      EDGE_BOTH: pin_evt = pin_rise_i | pin_fall_i;
      default:   pin_evt = 1'b0;
    endcase
  end

  assign evt    = mode_i.start & (mode_i.casc ? casc_i : pin_evt);
  // counter is closed to writes once the first event after start is taken
  assign locked = mode_i.start & (seen_q | evt);

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q  <= '0;
      reload_q <= '0;
      seen_q   <= 1'b0;
      uflow_q  <= 1'b0;
    end else begin
      uflow_q <= evt && (count_q == '0);
      if (!mode_i.start)
        seen_q <= 1'b0;
      else if (evt)
        seen_q <= 1'b1;
      if (wr_i)
        reload_q <= wr_data_i;
      if (wr_i && !locked)
        count_q <= wr_data_i;
      else if (evt)
        count_q <= (count_q == '0) ? reload_q : count_q - 1'b1;
    end
  end

  assign count_o = count_q;
  assign uflow_o = uflow_q;

  p_uflow_loads_reload_r2: assert property (@(posedge clk) disable iff (rst)
    uflow_q |-> count_q == $past(reload_q));

  p_count_step_r2: assert property (@(posedge clk) disable iff (rst)
    (evt && count_q != '0 && !wr_i) |=> count_q == $past(count_q) - 1'b1);

  p_stopped_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (!mode_i.start && !wr_i) |=> $stable(count_q));

  p_locked_write_r8: assert property (@(posedge clk) disable iff (rst)
    (mode_i.start && seen_q && wr_i && !evt) |=> $stable(count_q));

endmodule

// File: rtl/evt_tmr_ring.sv
module evt_tmr_ring
  import evt_tmr_pkg::*;
#(
  parameter int NUM_CH      = 3,
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2,
  localparam int ADDR_W     = $clog2(2 * NUM_CH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] pin_i,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wr_data,
  output logic [CNT_W-1:0]  rd_data,
  output logic              rd_valid,
  output logic [NUM_CH-1:0] irq
);

  chan_mode_t             mode_q [NUM_CH];
  logic [CNT_W-1:0]       count  [NUM_CH];
  logic [NUM_CH-1:0]      uflow;
  logic [CNT_W-1:0]       rd_mux;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    localparam int PREV = (i == 0) ? NUM_CH - 1 : i - 1;
    logic rise, fall, tmr_wr;

    assign tmr_wr = wr_en && (addr == ADDR_W'(2 * i));

    always_ff @(posedge clk) begin
      if (rst)
        mode_q[i] <= '0;
      else if (wr_en && addr == ADDR_W'(2 * i + 1))
        mode_q[i] <= chan_mode_t'(wr_data[MODE_W-1:0]);
    end

    evt_pin_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk    (clk),
      .rst    (rst),
      .pin_i  (pin_i[i]),
      .rise_o (rise),
      .fall_o (fall)
    );

    evt_chan #(.CNT_W(CNT_W)) u_chan (
      .clk        (clk),
      .rst        (rst),
      .mode_i     (mode_q[i]),
      .pin_rise_i (rise),
      .pin_fall_i (fall),
      .casc_i     (uflow[PREV]),
      .wr_i       (tmr_wr),
      .wr_data_i  (wr_data),
      .count_o    (count[i]),
      .uflow_o    (uflow[i])
    );
  end

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (addr == ADDR_W'(2 * i))
        rd_mux = count[i];
      else if (addr == ADDR_W'(2 * i + 1))
        rd_mux = CNT_W'(mode_q[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en)
        rd_data <= rd_mux;
    end
  end

  assign irq = uflow;

  p_rd_valid_r10: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(rd_en));

endmodule

// File: tb/evt_tmr_ring_bench.sv
module evt_tmr_ring_bench;

  localparam int NUM_CH = 3;
  localparam int CNT_W  = 16;
  localparam int ADDR_W = $clog2(2 * NUM_CH);

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [NUM_CH-1:0] pin_i = '0;
  logic              wr_en = 1'b0;
  logic              rd_en = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [CNT_W-1:0]  wr_data = '0;
  logic [CNT_W-1:0]  rd_data;
  logic              rd_valid;
  logic [NUM_CH-1:0] irq;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done   = 1'b0;
  int irq_cnt [NUM_CH];
  logic [CNT_W-1:0] exp_q [$];
  string            tag_q [$];

  always #5 clk = ~clk;

  evt_tmr_ring #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_evt_tmr_ring (
    .clk(clk), .rst(rst), .pin_i(pin_i), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .rd_valid(rd_valid),
    .irq(irq)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor: compare each returned read with the oldest expected item
  always @(negedge clk) begin
    cycles++;
    for (int i = 0; i < NUM_CH; i++)
      if (irq[i]) irq_cnt[i]++;
    if (rd_valid) begin
      if (exp_q.size() == 0)
        check(1'b0, "R10 unexpected read", int'(rd_data), -1);
      else begin
        logic [CNT_W-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(rd_data == e, t, int'(rd_data), int'(e));
      end
    end
  end

  task automatic reg_wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; addr = ADDR_W'(a); wr_data = CNT_W'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic reg_rd(input int a, input int exp, input string tag);
    @(negedge clk);
    rd_en = 1'b1; addr = ADDR_W'(a);
    exp_q.push_back(CNT_W'(exp));
    tag_q.push_back(tag);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic pulse(input int ch, input int hi);
    @(negedge clk);
    pin_i[ch] = 1'b1;
    repeat (hi) @(negedge clk);
    pin_i[ch] = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    wait (cycles > 100000);
    check(1'b0, "watchdog", cycles, 100000);
    finish_run();
  end

  initial begin
    for (int i = 0; i < NUM_CH; i++) irq_cnt[i] = 0;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check(irq == '0, "R1 irq after reset", int'(irq), 0);
    reg_rd(0, 0, "R1 ch0 count");
    reg_rd(1, 0, "R1 ch0 mode");
    reg_rd(4, 0, "R1 ch2 count");

    // R7 write while stopped, R10 mode layout, R3 rising only
    reg_wr(0, 3);
    reg_rd(0, 3, "R7 stopped write reaches counter");
    reg_wr(1, 9);                       // start, pin, rising
    reg_rd(1, 9, "R10 mode readback");
    pulse(0, 8);
    reg_rd(0, 2, "R3 rising edge counted once, fall ignored");

    // R8 write after first event goes to reload only
    reg_wr(0, 10);
    reg_rd(0, 2, "R8 running write leaves counter");
    pulse(0, 6);
    pulse(0, 6);
    reg_rd(0, 0, "R2 decrement to zero");
    pulse(0, 6);
    reg_rd(0, 10, "R8 new reload applied at underflow");
    check(irq_cnt[0] == 1, "R9 one irq cycle per underflow ch0", irq_cnt[0], 1);

    // R6 stopped channel ignores events
    reg_wr(1, 1);
    pulse(0, 6);
    reg_rd(0, 10, "R6 stopped count holds");

    // R3 falling edge only on ch1
    reg_wr(2, 5);
    reg_wr(3, 8);
    @(negedge clk); pin_i[1] = 1'b1;
    repeat (6) @(negedge clk);
    reg_rd(2, 5, "R3 falling mode ignores rise");
    @(negedge clk); pin_i[1] = 1'b0;
    repeat (6) @(negedge clk);
    reg_rd(2, 4, "R3 falling edge counted");

    // R3 both edges, R12 long hold counted once per edge
    reg_wr(4, 6);
    reg_wr(5, 10);
    pulse(2, 20);
    reg_rd(4, 4, "R12 both edges each counted once");

    // R4 cascade ch0 -> ch1, R5 pin ignored in cascade
    reg_wr(3, 0);
    reg_wr(2, 1);
    reg_wr(3, 12);
    reg_wr(0, 0);
    reg_wr(1, 9);
    pulse(0, 6);
    reg_rd(2, 0, "R4 ch1 counts ch0 underflow");
    pulse(1, 6);
    reg_rd(2, 0, "R5 pin ignored with cascade source");
    pulse(0, 6);
    reg_rd(2, 1, "R4 ch1 underflow reload");
    check(irq_cnt[1] == 1, "R9 ch1 irq count", irq_cnt[1], 1);

    // R4 ring wrap: ch0 fed by ch2
    reg_wr(1, 0);
    reg_wr(0, 2);
    reg_wr(1, 12);
    reg_wr(5, 2);
    reg_wr(4, 0);
    reg_wr(5, 10);
    pulse(2, 6);
    reg_rd(0, 0, "R4 ch0 counts ch2 underflows");
    check(irq_cnt[2] == 2, "R9 ch2 irq count", irq_cnt[2], 2);
    pulse(0, 6);
    reg_rd(0, 0, "R5 ch0 pin ignored in cascade");

    // R11 restart clears first-event record
    reg_wr(4, 7);
    reg_rd(4, 0, "R8 ch2 running write locked");
    reg_wr(5, 2);
    reg_wr(5, 10);
    reg_wr(4, 9);
    reg_rd(4, 9, "R11 write after restart reaches counter");
    check(irq_cnt[0] == 3, "R9 ch0 irq total", irq_cnt[0], 3);
    check(irq == '0, "R9 irq idle", int'(irq), 0);

    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R10 all reads returned", exp_q.size(), 0);
    finish_run();
  end

endmodule